// File: doc/BRIEF.md
# Serial Chain Readout Controller

This back-end controller drives two daisy chains of front-end boards from a 10 MHz reference clock. When the host issues an event readout command, the controller puts the chain into event mode. It then walks a 4-bit board address across the programmed number of boards and clocks a fixed-size word out of each board. It marks the first bit of every board word with a load strobe, so the addressed board can capture its parallel word into its shift register.

Between readouts, a period counter runs free. Each time it expires, the controller runs one monitor cycle. A monitor cycle holds the monitor reset line for one bit period and then sends a burst of monitor clock pulses. The burst length steps the selected monitor channel forward by one on every cycle and wraps after the last channel.

The host sets four things through a small write-only register port: the serial clock divider, the word size, the board count and the monitor period. A diagnostic mode sends a repeating 8-bit test pattern on a data line in step with the event clock. There is no streaming data path at the block edge, so every pin is a plain control or status level or pulse and none of them needs back-pressure.

Top module: `chain_ctrl`

## Requirements
- R1: After reset all chain outputs are low. This covers ch_sclk, ch_addr, ch_evt, ch_load, ch_tdata, mon_clk, mon_rst, evt_done and mon_attn. The register defaults are:
  - divider 4 (1 Mbit/s)
  - 48 bits per board
  - 16 boards
  - monitor period 10,000,000 cycles
  - test pattern off
- R2: While a transfer runs, ch_sclk is high for div+1 reference cycles and low for div+1 reference cycles. Its period is therefore 2*(div+1) cycles, where div is register 0.
- R3: Within an event transfer, rising edge number i of ch_sclk (counted from 0) carries ch_addr = i / bits, where bits is register 1. The transfer has exactly bits*boards rising edges, where boards is register 2 plus one.
- R4: At every rising edge of ch_sclk, ch_load is high exactly when i mod bits == 0, that is, on the first bit of each board word.
- R5: ch_evt is high at every rising edge of an event transfer. After the transfer, evt_done pulses high for a single cycle and ch_evt is low from that cycle onward.
- R6: ch_addr and ch_evt change only in cycles where ch_sclk is low.
- R7: Register 4 holds the test mode: bit 8 enables it and bits 7:0 hold the pattern. With the mode enabled, ch_tdata at rising edge i equals pattern bit 7 - ((i mod bits) mod 8), so the pattern goes out MSB first. With the mode disabled, ch_tdata is 0.
- R8: While no event transfer intervenes, successive rising edges of mon_rst are exactly period reference cycles apart, where period is register 3.
- R9: A monitor cycle holds mon_rst high for 2*(div+1) cycles with mon_clk low. It then gives (k mod 40)+1 mon_clk pulses, where k counts monitor cycles since reset. mon_attn pulses for one cycle after the last pulse.
- R10: A start command (any write to register 5 with data bit 0 set) is ignored while an event transfer or a monitor cycle is running. It produces no extra clock edges, no evt_done and no rise of ch_evt.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | 10 MHz reference clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 3 | Register select (0 div, 1 bits, 2 boards-1, 3 period, 4 test, 5 command) |
| reg_wdata | input | 24 | Register write data |
| ch_sclk | output | 1 | Event chain serial clock |
| ch_addr | output | 4 | Board address on the event chain |
| ch_evt | output | 1 | Event/monitor select, 1 = event |
| ch_load | output | 1 | Load strobe during the first bit of each board word |
| ch_tdata | output | 1 | Diagnostic test-pattern bit |
| mon_clk | output | 1 | Monitor chain clock |
| mon_rst | output | 1 | Monitor chain reset |
| evt_done | output | 1 | One-cycle pulse at the end of an event transfer |
| mon_attn | output | 1 | One-cycle pulse at the end of a monitor cycle |

## Verification
Suppose the bit counter or board counter inside the controller holds a wrong value. The address or load strobe is then wrong at the very next rising edge of ch_sclk, and the total edge count or the timing of evt_done shifts within one board word. If the channel selection register or the period counter goes wrong, the number of mon_clk pulses is off in that same monitor cycle, or the spacing between mon_rst rises moves by the time of the next expiry. A divider fault shows as a wrong high time within the first bit period.

// File: rtl/chain_pkg.sv
package chain_pkg;
  localparam logic [2:0] REG_DIV  = 3'd0;
  localparam logic [2:0] REG_BITS = 3'd1;
  localparam logic [2:0] REG_BRD  = 3'd2;
  localparam logic [2:0] REG_PER  = 3'd3;
  localparam logic [2:0] REG_TP   = 3'd4;
  localparam logic [2:0] REG_CMD  = 3'd5;

  typedef enum logic [1:0] {MON_IDLE, MON_RST, MON_PULSE} mon_st_t;
endpackage

// File: rtl/chain_baud.sv
module chain_baud #(
  parameter int DIV_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run,
  input  logic [DIV_W-1:0] div,
  output logic             sclk,
  output logic             fall
);
  logic [DIV_W-1:0] cnt;
  logic             wrap;

  assign wrap = run && (cnt == div);
  assign fall = wrap && sclk;

  always_ff @(posedge clk) begin
    if (!rst_n || !run) begin
      cnt  <= '0;
      sclk <= 1'b0;
    end else if (wrap) begin
      cnt  <= '0;
      sclk <= ~sclk;
    end else begin
      cnt <= cnt + 1'b1;
    end
  end

  // R2: the serial clock always starts from a low level
  a_r2_rest_low: assert property (@(posedge clk) disable iff (!rst_n)
    !run |=> !sclk);
endmodule

// File: rtl/chain_evt_seq.sv
module chain_evt_seq #(
  parameter int ADDR_W = 4,
  parameter int BIT_W  = 6
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              go,
  input  logic              fall,
  input  logic [BIT_W-1:0]  bits,
  input  logic [ADDR_W-1:0] last_brd,
  output logic              busy,
  output logic [ADDR_W-1:0] addr,
  output logic [BIT_W-1:0]  bitcnt,
  output logic              done
);
  logic [BIT_W-1:0] bit_last;
  assign bit_last = bits - 1'b1;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy   <= 1'b0;
      addr   <= '0;
      bitcnt <= '0;
      done   <= 1'b0;
    end else begin
      done <= 1'b0;
      if (!busy) begin
        if (go) begin
          busy   <= 1'b1;
          addr   <= '0;
          bitcnt <= '0;
        end
      end else if (fall) begin
        if (bitcnt == bit_last) begin
          bitcnt <= '0;
          if (addr == last_brd) begin
            busy <= 1'b0;
            done <= 1'b1;
            addr <= '0;
          end else begin
            addr <= addr + 1'b1;
          end
        end else begin
          bitcnt <= bitcnt + 1'b1;
        end
      end
    end
  end

  // R5: completion is a single-cycle pulse outside the busy window
  a_r5_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);
  a_r5_done_idle: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !busy);
endmodule

// File: rtl/chain_mon_seq.sv
module chain_mon_seq
  import chain_pkg::*;
#(
  parameter int PER_W = 24,
  parameter int NCHAN = 40,
  localparam int CH_W = $clog2(NCHAN)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [PER_W-1:0] period,
  input  logic             evt_busy,
  input  logic             evt_go,
  input  logic             fall,
  output logic             busy,
  output logic             rst_phase,
  output logic             pulse_phase,
  output logic             attn
);
  mon_st_t          st;
  logic [PER_W-1:0] pcnt;
  logic             pend, expire, start;
  logic [CH_W-1:0]  chan, k;

  assign expire      = (pcnt >= period - 1'b1);
  assign start       = (st == MON_IDLE) && pend && !evt_busy && !evt_go;
  assign busy        = (st != MON_IDLE);
  assign rst_phase   = (st == MON_RST);
  assign pulse_phase = (st == MON_PULSE);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pcnt <= '0;
      pend <= 1'b0;
      st   <= MON_IDLE;
      chan <= '0;
      k    <= '0;
      attn <= 1'b0;
    end else begin
      attn <= 1'b0;
      pcnt <= expire ? '0 : pcnt + 1'b1;
      pend <= (pend && !start) || expire;
      case (st)
        MON_IDLE: if (start) st <= MON_RST;
        MON_RST: if (fall) begin
          st <= MON_PULSE;
          k  <= '0;
        end
        MON_PULSE: if (fall) begin
          if (k == chan) begin
            st   <= MON_IDLE;
            attn <= 1'b1;
            chan <= (chan == CH_W'(NCHAN - 1)) ? '0 : chan + 1'b1;
          end else begin
            k <= k + 1'b1;
          end
        end
        default: st <= MON_IDLE;
      endcase
    end
  end

  // R9: channel selection stays in range, attention is one cycle long
  a_r9_chan_range: assert property (@(posedge clk) disable iff (!rst_n)
    chan < CH_W'(NCHAN));
  a_r9_attn_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    attn |=> !attn);
  // R10: a monitor cycle never overlaps an event transfer
  a_r10_no_overlap: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> !evt_busy);
endmodule

// File: rtl/chain_ctrl.sv
module chain_ctrl
  import chain_pkg::*;
#(
  parameter int ADDR_W = 4,
  parameter int BIT_W  = 6,
  parameter int DIV_W  = 8,
  parameter int PER_W  = 24,
  parameter int NCHAN  = 40
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_we,
  input  logic [2:0]        reg_addr,
  input  logic [PER_W-1:0]  reg_wdata,
  output logic              ch_sclk,
  output logic [ADDR_W-1:0] ch_addr,
  output logic              ch_evt,
  output logic              ch_load,
  output logic              ch_tdata,
  output logic              mon_clk,
  output logic              mon_rst,
  output logic              evt_done,
  output logic              mon_attn
);
  logic [DIV_W-1:0]  r_div;
  logic [BIT_W-1:0]  r_bits;
  logic [ADDR_W-1:0] r_last;
  logic [PER_W-1:0]  r_per;
  logic              r_tp_en;
  logic [7:0]        r_pat;

  logic              evt_busy, mon_busy, go, sclk, fall, pulse_phase;
  logic [BIT_W-1:0]  bitcnt;
  logic [2:0]        pat_idx;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      r_div   <= DIV_W'(4);
      r_bits  <= BIT_W'(48);
      r_last  <= '1;
      r_per   <= PER_W'(10_000_000);
      r_tp_en <= 1'b0;
      r_pat   <= '0;
    end else if (reg_we) begin
      case (reg_addr)
        REG_DIV:  r_div  <= reg_wdata[DIV_W-1:0];
        REG_BITS: r_bits <= reg_wdata[BIT_W-1:0];
        REG_BRD:  r_last <= reg_wdata[ADDR_W-1:0];
        REG_PER:  r_per  <= reg_wdata;
        REG_TP: begin
          r_tp_en <= reg_wdata[8];
          r_pat   <= reg_wdata[7:0];
        end
        default: ;
      endcase
    end
  end

  assign go = reg_we && (reg_addr == REG_CMD) && reg_wdata[0] && !evt_busy && !mon_busy;

  chain_baud #(.DIV_W(DIV_W)) u_baud (
    .clk(clk), .rst_n(rst_n), .run(evt_busy | mon_busy), .div(r_div),
    .sclk(sclk), .fall(fall)
  );

  chain_evt_seq #(.ADDR_W(ADDR_W), .BIT_W(BIT_W)) u_evt (
    .clk(clk), .rst_n(rst_n), .go(go), .fall(fall), .bits(r_bits),
    .last_brd(r_last), .busy(evt_busy), .addr(ch_addr), .bitcnt(bitcnt),
    .done(evt_done)
  );

  chain_mon_seq #(.PER_W(PER_W), .NCHAN(NCHAN)) u_mon (
    .clk(clk), .rst_n(rst_n), .period(r_per), .evt_busy(evt_busy), .evt_go(go),
    .fall(fall), .busy(mon_busy), .rst_phase(mon_rst), .pulse_phase(pulse_phase),
    .attn(mon_attn)
  );

  assign pat_idx  = 3'd7 - bitcnt[2:0];
  assign ch_sclk  = sclk & evt_busy;
  assign ch_evt   = evt_busy;
  assign ch_load  = evt_busy && (bitcnt == '0);
  assign ch_tdata = evt_busy && r_tp_en && r_pat[pat_idx];
  assign mon_clk  = sclk & pulse_phase;

  // R6: address and select settle only while the serial clock is low
  a_r6_addr_low: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(ch_addr) |-> !ch_sclk);
  a_r6_evt_low: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(ch_evt) |-> !ch_sclk);
  // R9: no monitor clock while monitor reset is held
  a_r9_rst_no_clk: assert property (@(posedge clk) disable iff (!rst_n)
    mon_rst |-> !mon_clk);
  // R3: the address never passes the last programmed board
  a_r3_addr_range: assert property (@(posedge clk) disable iff (!rst_n)
    ch_evt |-> (ch_addr <= r_last));
endmodule

// File: tb/sim_chain_ctrl.sv
`timescale 1ns/1ps
module sim_chain_ctrl;
  localparam int CLK_NS = 100;

  logic clk = 1'b0, rst_n = 1'b0, reg_we = 1'b0;
  logic [2:0] reg_addr = '0;
  logic [23:0] reg_wdata = '0;
  logic ch_sclk, ch_evt, ch_load, ch_tdata, mon_clk, mon_rst, evt_done, mon_attn;
  logic [3:0] ch_addr;

  int tests = 0, fails = 0, cyc = 0, mon_k = 0;

  chain_ctrl u0 (
    .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .ch_sclk(ch_sclk), .ch_addr(ch_addr), .ch_evt(ch_evt),
    .ch_load(ch_load), .ch_tdata(ch_tdata), .mon_clk(mon_clk), .mon_rst(mon_rst),
    .evt_done(evt_done), .mon_attn(mon_attn)
  );

  always #(CLK_NS/2) clk = ~clk;

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc > 190000) begin
      fails = fails + 1;
      $display("FAIL watchdog: act %0d cycles exp below 190000", cyc);
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: act %0d exp %0d", req, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [23:0] d);
    @(negedge clk);
    reg_we = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_we = 1'b0;
  endtask

  function automatic int exp_tdata(int i, int bits, bit tp, logic [7:0] pat);
    int b = (i % bits) % 8;
    return tp ? int'(pat[7 - b]) : 0;
  endfunction

  task automatic run_evt(input int dv, input int bits, input int brds, input bit tp,
                         input logic [7:0] pat, input int inj_at);
    int rises = 0, e_addr = 0, e_load = 0, e_evt = 0, e_td = 0, e_hi = 0, e_per = 0;
    int e_stab = 0, hl = 0, since = 0, lim = 0, tail_bad = 0;
    bit prev = 0, seen = 0, injected = 0;
    logic [3:0] pa = '0;
    wr(3'd0, 24'(dv)); wr(3'd1, 24'(bits)); wr(3'd2, 24'(brds - 1));
    wr(3'd4, {15'd0, tp, pat});
    wr(3'd5, 24'd1);
    pa = ch_addr;
    while (!seen && lim < 60000) begin
      @(negedge clk);
      lim++;
      if (reg_we) reg_we = 1'b0;
      since++;
      if (ch_sclk && !prev) begin
        if (ch_addr != 4'(rises / bits)) e_addr++;
        if (ch_load != (rises % bits == 0)) e_load++;
        if (!ch_evt) e_evt++;
        if (int'(ch_tdata) != exp_tdata(rises, bits, tp, pat)) e_td++;
        if (rises > 0 && since != 2 * (dv + 1)) e_per++;
        since = 0;
        rises++;
        if (rises == inj_at && !injected) begin
          reg_we = 1'b1; reg_addr = 3'd5; reg_wdata = 24'd1; injected = 1;
        end
      end
      if (ch_sclk) hl++;
      if (prev && !ch_sclk) begin
        if (hl != dv + 1) e_hi++;
        hl = 0;
      end
      if (ch_addr != pa && ch_sclk) e_stab++;
      pa = ch_addr;
      prev = ch_sclk;
      if (evt_done) begin
        seen = 1;
        if (ch_evt) e_evt++;
      end
    end
    for (int t = 0; t < 4 * (dv + 1) + 4; t++) begin
      @(negedge clk);
      if (ch_evt || ch_sclk || evt_done) tail_bad++;
    end
    chk(seen, "R5 done pulse seen", int'(seen), 1);
    chk(rises == bits * brds, "R3 rising edge count", rises, bits * brds);
    chk(e_addr == 0, "R3 address per edge", e_addr, 0);
    chk(e_load == 0, "R4 load strobe", e_load, 0);
    chk(e_evt == 0, "R5 select level", e_evt, 0);
    chk(e_td == 0, "R7 test pattern bits", e_td, 0);
    chk(e_hi == 0 && e_per == 0, "R2 clock high time and period", e_hi + e_per, 0);
    chk(e_stab == 0, "R6 address stable while clock high", e_stab, 0);
    chk(tail_bad == 0, inj_at > 0 ? "R10 start ignored while busy" : "R5 idle after done",
        tail_bad, 0);
  endtask

  task automatic run_mon(input int dv, input int per, input int ncyc);
    int done_c = 0, n_rst = 0, last_rise = 0, now = 0, rl = 0, pulses = 0, lim = 0;
    int e_int = 0, e_rl = 0, e_cnt = 0, e_both = 0, e_evt = 0;
    bit prst = 0, pclk = 0;
    wr(3'd0, 24'(dv)); wr(3'd3, 24'(per));
    while (done_c < ncyc && lim < 80000) begin
      @(negedge clk);
      lim++; now++;
      if (reg_we) reg_we = 1'b0;
      if (mon_rst && !prst) begin
        if (n_rst >= 2 && now - last_rise != per) e_int++;
        last_rise = now;
        n_rst++;
        pulses = 0;
        if (n_rst == 2) begin
          reg_we = 1'b1; reg_addr = 3'd5; reg_wdata = 24'd1;
        end
      end
      if (mon_rst) rl++;
      if (prst && !mon_rst) begin
        if (rl != 2 * (dv + 1)) e_rl++;
        rl = 0;
      end
      if (mon_clk && !pclk) pulses++;
      if (mon_clk && mon_rst) e_both++;
      if (ch_evt) e_evt++;
      if (mon_attn) begin
        if (pulses != (mon_k % 40) + 1) begin
          e_cnt++;
          $display("FAIL R9 pulse count cycle %0d: act %0d exp %0d", mon_k, pulses,
                   (mon_k % 40) + 1);
        end
        mon_k++;
        done_c++;
      end
      prst = mon_rst;
      pclk = mon_clk;
    end
    wr(3'd3, 24'hFFFFFF);
    chk(done_c == ncyc, "R9 monitor cycles completed", done_c, ncyc);
    chk(e_int == 0, "R8 monitor period spacing", e_int, 0);
    chk(e_rl == 0 && e_both == 0, "R9 reset phase length", e_rl + e_both, 0);
    chk(e_cnt == 0, "R9 channel step pulses", e_cnt, 0);
    chk(e_evt == 0, "R10 start ignored during monitor", e_evt, 0);
  endtask

  initial begin
    int s;
    s = int'($urandom(32'd20091016));
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk({ch_sclk, ch_addr, ch_evt, ch_load, ch_tdata, mon_clk, mon_rst, evt_done,
         mon_attn} == '0, "R1 reset outputs low",
        int'({ch_sclk, ch_addr, ch_evt, ch_load, ch_tdata, mon_clk, mon_rst}), 0);
    run_evt(4, 48, 16, 1'b0, 8'h00, 0);
    run_evt(0, 1, 1, 1'b1, 8'hA5, 0);
    run_evt(1, 8, 16, 1'b1, 8'h81, 0);
    run_evt(2, 10, 3, 1'b1, 8'h3C, 12);
    for (int n = 0; n < 5; n++) begin
      int dv = int'($urandom_range(5, 0));
      int bits = int'($urandom_range(20, 1));
      int brds = int'($urandom_range(16, 1));
      bit tp = 1'($urandom_range(1, 0));
      logic [7:0] pat = 8'($urandom_range(255, 0));
      run_evt(dv, bits, brds, tp, pat, 0);
    end
    run_mon(0, 120, 42);
    run_mon(2, 400, 3);
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule